// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Overflow Trap

This block is the integer execution unit of a 32-bit pipeline. Each cycle it can accept one operation: two kinds of addition, subtraction, three bitwise functions and two logical shifts. One clock edge after an operation is accepted, the block presents the result together with four condition flags: sign, zero, carry and low-byte parity. It also presents a write-enable that tells the register file to commit the result.

The signed add and subtract forms check for two's-complement overflow. When overflow occurs, the block pulses a trap line and withholds the write-enable. It also latches the instruction address that came with the operation into an exception program counter, so the handler can read that address back. The unsigned forms wrap silently. The flags update on every accepted operation, including one that traps, so a later stage can test them without reading the result.

Top module: `alu_trap_unit`

## Requirements
- R1: Opcodes (op_code): 0 add-signed, 1 add-immediate-signed, 2 add-unsigned, 3 add-immediate-unsigned, 4 subtract-signed, 5 subtract-unsigned, 6 AND, 7 OR, 8 NOR, 9 shift-left-logical, 10 shift-right-logical. Both shifts take their shift amount from opnd_b[4:0].
- R2: Subtraction is computed as opnd_a + ~opnd_b + 1. Its carry flag is the carry out of bit 31 of that sum, so 1 means no borrow.
- R3: flag_sign equals result bit 31, and flag_zero is 1 exactly when every result bit is 0.
- R4: flag_parity is 1 when result[7:0] holds an even number of ones.
- R5: For the add forms, flag_carry is 1 exactly when the unsigned sum of the operands exceeds 2^32-1.
- R6: Signed addition overflows only when both operands share a sign and the result's sign differs from that sign.
- R7: Signed subtraction overflows only when the operand signs differ and the result's sign differs from opnd_a.
- R8: When a signed operation overflows, trap is high for exactly one cycle and wr_en stays low. Flags and result (the wrapped value) still update.
- R9: epc loads instr_addr of the operation that trapped, holds its value at all other times, and reads 0 after reset.
- R10: The unsigned add and subtract forms never trap. They write their wrapped result with wr_en high.
- R11: AND, OR, NOR and the shifts clear flag_carry and never trap.
- R12: Outputs appear one clock after op_valid. On a cycle without an operation, wr_en and trap are 0 and result and flags hold. Reset clears every output.
- R13: Opcodes 11 to 15 are ignored: no write, no trap, and result, flags and epc keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select (see R1) |
| opnd_a | input | 32 | First operand / minuend / shift source |
| opnd_b | input | 32 | Second operand / subtrahend / shift amount |
| instr_addr | input | 32 | Address of the instruction carrying the operation |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Commit the result to the destination |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_carry | output | 1 | Carry flag |
| flag_parity | output | 1 | Low-byte even-parity flag |
| trap | output | 1 | Overflow trap pulse |
| epc | output | 32 | Exception program counter |

## Verification
The trap and the flag update can fall in the same cycle, and the trap must not stop the flags from landing. The bench provokes this with 0x80000000 + 0x80000000 on the signed add. That operation yields a zero result with carry set while it traps. The bench then expects trap high, wr_en low, epc equal to the issuing address, and zero, carry, sign and parity flags equal to the values computed for the wrapped sum. It also issues trapping operations back to back to confirm that each one reloads epc and pulses trap for one cycle only.

// File: rtl/alu_trap_pkg.sv
// Package: shared opcode encoding and decoded-control record for the ALU.
package alu_trap_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDI  = 4'd1,
        OP_ADDU  = 4'd2,
        OP_ADDIU = 4'd3,
        OP_SUB   = 4'd4,
        OP_SUBU  = 4'd5,
        OP_AND   = 4'd6,
        OP_OR    = 4'd7,
        OP_NOR   = 4'd8,
        OP_SLL   = 4'd9,
        OP_SRL   = 4'd10
    } alu_op_e;

    typedef enum logic [2:0] {
        LU_AND,
        LU_OR,
        LU_NOR,
        LU_SLL,
        LU_SRL
    } logic_fn_e;

    typedef struct packed {
        logic      known;       // opcode is defined
        logic      use_adder;   // result comes from the adder
        logic      subtract;    // adder computes a + ~b + 1
        logic      check_ovf;   // signed form: overflow traps
        logic_fn_e lfn;         // bitwise/shift function
    } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
// Module: alu_decode
// Turns the 4-bit opcode into the control record. Assumes undefined codes
// must produce known=0 so the top ignores them.
module alu_decode
    import alu_trap_pkg::*;
(
    input  logic [3:0] op_code,
    output alu_ctrl_t  ctrl
);
    // Purpose: map each opcode onto datapath controls.
    always_comb begin
        ctrl = '{known: 1'b1, use_adder: 1'b0, subtract: 1'b0,
                 check_ovf: 1'b0, lfn: LU_AND};
        unique case (op_code)
            OP_ADD, OP_ADDI:   begin ctrl.use_adder = 1'b1; ctrl.check_ovf = 1'b1; end
            OP_ADDU, OP_ADDIU: ctrl.use_adder = 1'b1;
            OP_SUB:            begin ctrl.use_adder = 1'b1; ctrl.subtract = 1'b1;
                                     ctrl.check_ovf = 1'b1; end
            OP_SUBU:           begin ctrl.use_adder = 1'b1; ctrl.subtract = 1'b1; end
            OP_AND:            ctrl.lfn = LU_AND;
            OP_OR:             ctrl.lfn = LU_OR;
            OP_NOR:            ctrl.lfn = LU_NOR;
            OP_SLL:            ctrl.lfn = LU_SLL;
            OP_SRL:            ctrl.lfn = LU_SRL;
            default:           ctrl.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_adder.sv
// Module: alu_adder
// Add/subtract with carry out and signed-overflow detection. Subtraction
// inverts the second operand and injects a carry of one.
module alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             subtract,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    // Purpose: form the effective operand and the widened sum.
    always_comb begin
        b_eff     = subtract ? ~b : b;
        wide      = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
        sum       = wide[MSB:0];
        carry_out = wide[WIDTH];
    end

    // Purpose: overflow when the effective operands agree in sign and the sum does not.
    always_comb begin
        overflow = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
// Module: alu_logic
// Bitwise functions and logical shifts; shift amount from low bits of b.
module alu_logic
    import alu_trap_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        lfn,
    output logic [WIDTH-1:0] y
);
    localparam int SHW = $clog2(WIDTH);

    logic [SHW-1:0] shamt;

    // Purpose: select the bitwise or shift result.
    always_comb begin
        shamt = b[SHW-1:0];
        unique case (lfn)
            LU_AND:  y = a & b;
            LU_OR:   y = a | b;
            LU_NOR:  y = ~(a | b);
            LU_SLL:  y = a << shamt;
            LU_SRL:  y = a >> shamt;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_flags.sv
// Module: alu_flags
// Derives sign, zero and low-byte parity from a result; passes carry.
module alu_flags #(
    parameter int WIDTH    = 32,
    parameter int PAR_BITS = 8
) (
    input  logic [WIDTH-1:0] y,
    input  logic             carry_in,
    output logic [3:0]       flags    // {sign, zero, carry, parity}
);
    // Purpose: compute the four condition bits.
    always_comb begin
        flags[3] = y[WIDTH-1];
        flags[2] = (y == '0);
        flags[1] = carry_in;
        flags[0] = ~^y[PAR_BITS-1:0];
    end
endmodule

// File: rtl/alu_trap_unit.sv
// Module: alu_trap_unit
// Top of the ALU: decode, adder, logic unit, flags, and the registered
// result/flag/trap/EPC stage. Assumes one operation per op_valid cycle
// and a synchronous active-low reset.
module alu_trap_unit
    import alu_trap_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int PAR_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [WIDTH-1:0] instr_addr,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic             flag_sign,
    output logic             flag_zero,
    output logic             flag_carry,
    output logic             flag_parity,
    output logic             trap,
    output logic [WIDTH-1:0] epc
);
    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] add_y, log_y, res_d;
    logic             add_c, add_ovf, carry_d, trap_d;
    logic [3:0]       flags_d, flags_q;

    alu_decode u_dec (.op_code(op_code), .ctrl(ctrl));

    alu_adder #(.WIDTH(WIDTH)) u_add (
        .a(opnd_a), .b(opnd_b), .subtract(ctrl.subtract),
        .sum(add_y), .carry_out(add_c), .overflow(add_ovf));

    alu_logic #(.WIDTH(WIDTH)) u_log (
        .a(opnd_a), .b(opnd_b), .lfn(ctrl.lfn), .y(log_y));

    alu_flags #(.WIDTH(WIDTH), .PAR_BITS(PAR_BITS)) u_flg (
        .y(res_d), .carry_in(carry_d), .flags(flags_d));

    // Purpose: choose result, carry and trap condition for this operation.
    always_comb begin
        res_d   = ctrl.use_adder ? add_y : log_y;
        carry_d = ctrl.use_adder & add_c;
        trap_d  = ctrl.check_ovf & add_ovf;
    end

    // Purpose: register outputs, pulse trap/write and capture the EPC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            flags_q <= '0;
            wr_en   <= 1'b0;
            trap    <= 1'b0;
            epc     <= '0;
        end else begin
            wr_en <= 1'b0;
            trap  <= 1'b0;
            if (op_valid && ctrl.known) begin
                result  <= res_d;
                flags_q <= flags_d;
                wr_en   <= !trap_d;
                trap    <= trap_d;
                if (trap_d) begin
                    epc <= instr_addr;
                end
            end
        end
    end

    assign {flag_sign, flag_zero, flag_carry, flag_parity} = flags_q;
endmodule

// File: rtl/alu_trap_unit_chk.sv
// Module: alu_trap_unit_chk
// Property checker bound to alu_trap_unit; observes ports only.
module alu_trap_unit_chk
    import alu_trap_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [3:0]  op_code,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [31:0] instr_addr,
    input logic [31:0] result,
    input logic        wr_en,
    input logic        flag_sign,
    input logic        flag_zero,
    input logic        flag_carry,
    input logic        flag_parity,
    input logic        trap,
    input logic [31:0] epc
);
    logic is_unsigned, is_logic, is_known;

    // Purpose: classify the presented opcode.
    always_comb begin
        is_unsigned = (op_code == OP_ADDU) || (op_code == OP_ADDIU) || (op_code == OP_SUBU);
        is_logic    = (op_code >= OP_AND) && (op_code <= OP_SRL);
        is_known    = (op_code <= OP_SRL);
    end

    AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_known) |=> (flag_sign == result[31]) && (flag_zero == (result == 32'd0))); // R3
    AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_known) |=> (flag_parity == ~^result[7:0])); // R4
    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !wr_en); // R8
    AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && !$past(op_valid)) |-> 1'b0 || !trap); // R8
    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (epc == $past(instr_addr))); // R9
    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |-> $stable(epc)); // R9
    AST_UNSIGNED_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_unsigned) |=> (!trap && wr_en)); // R10
    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_logic) |=> (!flag_carry && !trap)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && is_known) |=> (!wr_en && !trap && $stable(result))); // R12 R13
endmodule

bind alu_trap_unit alu_trap_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .instr_addr(instr_addr),
    .result(result), .wr_en(wr_en), .flag_sign(flag_sign),
    .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_parity(flag_parity),
    .trap(trap), .epc(epc));

// File: tb/alu_trap_unit_tb.sv
// Directed bench for alu_trap_unit: one task per scenario.
module alu_trap_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0, instr_addr = '0;
    logic [31:0] result, epc;
    logic        wr_en, flag_sign, flag_zero, flag_carry, flag_parity, trap;

    int n_checks = 0;
    int n_errors = 0;

    // expected architectural state
    logic [31:0] e_res = '0, e_epc = '0;
    logic [3:0]  e_flg = '0;

    always #2 clk = ~clk;

    alu_trap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .instr_addr(instr_addr),
        .result(result), .wr_en(wr_en), .flag_sign(flag_sign),
        .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_parity(flag_parity),
        .trap(trap), .epc(epc));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation, model it from the requirements, and check all outputs.
    task automatic run_op(input string req, input logic [3:0] op,
                          input logic [31:0] a, input logic [31:0] b, input logic [31:0] pc);
        logic [32:0] w;
        logic [31:0] be, r;
        logic        sub, sgn, add, c, ovf, tr, known;
        sub   = (op == 4'd4) || (op == 4'd5);
        sgn   = (op == 4'd0) || (op == 4'd1) || (op == 4'd4);
        add   = (op <= 4'd5);
        known = (op <= 4'd10);
        be    = sub ? ~b : b;
        w     = {1'b0, a} + {1'b0, be} + {32'd0, sub};
        case (op)
            4'd6:    r = a & b;
            4'd7:    r = a | b;
            4'd8:    r = ~(a | b);
            4'd9:    r = a << b[4:0];
            4'd10:   r = a >> b[4:0];
            default: r = w[31:0];
        endcase
        c   = add & w[32];
        ovf = sub ? (a[31] != b[31]) && (r[31] != a[31])
                  : (a[31] == b[31]) && (r[31] != a[31]);
        tr  = sgn & ovf;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b; instr_addr = pc;
        @(negedge clk);
        op_valid = 1'b0;
        if (known) begin
            e_res = r;
            e_flg = {r[31], r == 32'd0, c, ~^r[7:0]};
            if (tr) e_epc = pc;
        end
        chk({req, " result"}, result, e_res);
        chk({req, " flags"}, {28'd0, flag_sign, flag_zero, flag_carry, flag_parity}, {28'd0, e_flg});
        chk({req, " trap"}, {31'd0, trap}, {31'd0, known & tr});
        chk({req, " wr_en"}, {31'd0, wr_en}, {31'd0, known & ~tr});
        chk({req, " epc"}, epc, e_epc);
    endtask

    task automatic t_reset();
        chk("R12 reset result", result, 32'd0);
        chk("R12 reset flags", {28'd0, flag_sign, flag_zero, flag_carry, flag_parity}, 32'd0);
        chk("R12 reset wr/trap", {30'd0, wr_en, trap}, 32'd0);
        chk("R9 reset epc", epc, 32'd0);
    endtask

    task automatic t_add();
        run_op("R1 R5 add small", 4'd2, 32'd5, 32'd6, 32'h100);
        run_op("R5 addu carry wrap", 4'd3, 32'hFFFF_FFFF, 32'd1, 32'h104);
        run_op("R6 signed diff signs", 4'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h108);
        run_op("R6 signed add ok", 4'd1, 32'd100, 32'd27, 32'h10C);
    endtask

    task automatic t_sub();
        run_op("R2 sub 12-5", 4'd5, 32'd12, 32'd5, 32'h200);
        run_op("R2 sub borrow", 4'd5, 32'd5, 32'd12, 32'h204);
        run_op("R7 sub same signs", 4'd4, 32'h8000_0000, 32'hFFFF_FFFF, 32'h208);
    endtask

    task automatic t_trap();
        run_op("R8 R3 add trap zero+carry", 4'd0, 32'h8000_0000, 32'h8000_0000, 32'h300);
        run_op("R8 R6 addi trap pos", 4'd1, 32'h7FFF_FFFF, 32'd1, 32'h304);
        run_op("R7 R9 sub trap", 4'd4, 32'h8000_0000, 32'd1, 32'h308);
        run_op("R7 sub trap pos", 4'd4, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h30C);
        run_op("R10 addu no trap", 4'd2, 32'h7FFF_FFFF, 32'd1, 32'h310);
        run_op("R10 subu no trap", 4'd5, 32'h8000_0000, 32'd1, 32'h314);
    endtask

    task automatic t_logic();
        run_op("R11 and", 4'd6, 32'hF0F0_1234, 32'hFF00_FF0F, 32'h400);
        run_op("R11 or", 4'd7, 32'h0000_00F0, 32'h0000_000E, 32'h404);
        run_op("R11 nor", 4'd8, 32'h0000_0000, 32'h0000_0000, 32'h408);
        run_op("R1 sll", 4'd9, 32'h0000_0001, 32'd31, 32'h40C);
        run_op("R1 srl", 4'd10, 32'h8000_0000, 32'd35, 32'h410);
        run_op("R4 parity odd", 4'd7, 32'h0000_0007, 32'd0, 32'h414);
    endtask

    task automatic t_ignore();
        run_op("R8 setup trap", 4'd0, 32'h4000_0000, 32'h4000_0000, 32'h500);
        run_op("R13 undefined op", 4'd15, 32'h1234_5678, 32'h1, 32'h504);
        run_op("R13 undefined op 11", 4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h508);
        @(negedge clk);
        chk("R12 idle wr/trap", {30'd0, wr_en, trap}, 32'd0);
        chk("R12 idle result held", result, e_res);
        chk("R9 epc held", epc, e_epc);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                t_add();
                t_sub();
                t_trap();
                t_logic();
                t_ignore();
            end
            begin
                repeat (20000) @(negedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule